// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the up and down pulses of a phase frequency detector on a fast sampling clock. For every reference period it counts the number of sampling cycles in which either pulse is active. At each reference strobe it compares that width with two limits: a tight one for gaining lock and a wider one for losing it. Lock is granted after a run of consecutive small errors. The run length is three or five reference periods, chosen by a precision input. Once locked, the flag falls on the first period with a large error.

Two charge-pump controls, high impedance and power-down, force the detector to the unlocked state with an empty run counter at once. A raw mode bypasses the counting. In that mode the output is the inverse of the combined phase pulses: high between pulses and low while a pulse is active, the same waveform an open-drain pin with a pull-up would give. The sampling clock, the strobe and the pulses all come from the same clock domain.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset the detector is unlocked with an empty run counter, and `lock_out` is 0 in counting mode. The first `ref_tick` after reset only opens a measurement window and is not evaluated.
- R2: The error width of a window is the number of sampling cycles with `pump_up` or `pump_dn` high. A window starts at the cycle in which `ref_tick` is high and ends just before the next `ref_tick`. A width below `GOOD_LIMIT` (default 15) is good, and a width above `BAD_LIMIT` (default 30) is bad. The state changes only at an evaluated `ref_tick` or under a force.
- R3: With `precise_sel`=0, the third consecutive good evaluation sets `lock_out` to 1 on the clock edge that samples that `ref_tick`. The first and second good evaluations leave it at 0.
- R4: With `precise_sel`=1, lock needs five consecutive good evaluations. Four leave `lock_out` at 0.
- R5: While unlocked, an evaluation whose width is `GOOD_LIMIT` or more clears the run counter. The count restarts from zero.
- R6: While locked, a single evaluation with a width above `BAD_LIMIT` clears the lock at that edge. The pulse direction does not matter.
- R7: While locked, widths from `GOOD_LIMIT` through `BAD_LIMIT` keep the lock.
- R8: While `cp_hiz` or `cp_off` is high, the detector is unlocked and the run counter is zero from the next clock edge, whether or not a strobe occurs. Once both are low, a full run of good evaluations is needed again.
- R9: With `raw_mode`=1, `lock_out` equals NOT(`pump_up` OR `pump_dn`) combinationally, whatever the lock state.
- R10: A change of `precise_sel` while unlocked applies at the next evaluation. Goods already counted stay counted, so three goods under `precise_sel`=1 followed by one good under `precise_sel`=0 give lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference period strobe |
| pump_up | input | 1 | Detector up pulse |
| pump_dn | input | 1 | Detector down pulse |
| precise_sel | input | 1 | 0: three goods for lock, 1: five goods |
| cp_hiz | input | 1 | Charge pump in high impedance, forces unlock |
| cp_off | input | 1 | Charge pump powered down, forces unlock |
| raw_mode | input | 1 | 1: output follows inverted pulses |
| lock_out | output | 1 | Lock flag or raw pulse level |

## Verification
The hardest state to reach from the ports is a run counter that holds three goods under the long precision setting when the setting is then switched to the short one. Reaching it needs an unbroken series of windows of exact width, with the select changed between two strobes. The bench builds every window with one task that opens the window with a strobe and drives a pulse of exactly the chosen number of cycles. This lets it place the widths 14, 15, 30 and 31 at the limits and switch the select between windows. The same task, run while a force input is held, shows that good windows cannot build up a run while the pump is disabled.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  function automatic logic width_is_good(input int unsigned width, input int unsigned limit);
    return width < limit;
  endfunction

  function automatic logic width_is_bad(input int unsigned width, input int unsigned limit);
    return width > limit;
  endfunction

  function automatic int unsigned runs_needed(input logic precise, input int unsigned short_run,
                                              input int unsigned long_run);
    return precise ? long_run : short_run;
  endfunction

endpackage

// File: rtl/lockdet_width_meter.sv
module lockdet_width_meter #(
  parameter int unsigned CW      = 6,
  parameter int unsigned SAT_VAL = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          pump_up,
  input  logic          pump_dn,
  output logic [CW-1:0] width_o,
  output logic          window_ok_o
);
  localparam logic [CW-1:0] SAT = CW'(SAT_VAL);

  logic          err_now;
  logic [CW-1:0] cnt_q;
  logic          open_q;

  assign err_now = pump_up | pump_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (ref_tick) begin
      cnt_q  <= err_now ? CW'(1) : '0;
      open_q <= 1'b1;
    end else if (err_now && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign width_o     = cnt_q;
  assign window_ok_o = open_q;
endmodule

// File: rtl/lockdet_run_ctrl.sv
module lockdet_run_ctrl
  import lockdet_pkg::*;
#(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5,
  parameter int unsigned RW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval_tick,
  input  logic          good_cycle,
  input  logic          bad_cycle,
  input  logic          force_unlock,
  input  logic          precise_sel,
  output logic          locked_o,
  output logic [RW-1:0] run_o,
  output logic          enter_lock_o,
  output logic          drop_lock_o
);
  localparam logic [RW-1:0] RUN_CAP = RW'(LONG_RUN);

  logic          locked_q;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_inc;
  logic [RW-1:0] need;

  assign need    = RW'(runs_needed(precise_sel, SHORT_RUN, LONG_RUN));
  assign run_inc = (run_q >= RUN_CAP) ? run_q : run_q + 1'b1;

  assign enter_lock_o = eval_tick && !force_unlock && !locked_q && good_cycle && (run_inc >= need);
  assign drop_lock_o  = eval_tick && !force_unlock && locked_q && bad_cycle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      run_q    <= '0;
    end else if (force_unlock) begin
      locked_q <= 1'b0;
      run_q    <= '0;
    end else if (eval_tick && !locked_q) begin
      if (good_cycle) begin
        run_q <= run_inc;
        if (enter_lock_o) locked_q <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end else if (drop_lock_o) begin
      locked_q <= 1'b0;
      run_q    <= '0;
    end
  end

  assign locked_o = locked_q;
  assign run_o    = run_q;
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lockdet_pkg::*;
#(
  parameter int unsigned GOOD_LIMIT = 15,
  parameter int unsigned BAD_LIMIT  = 30,
  parameter int unsigned SHORT_RUN  = 3,
  parameter int unsigned LONG_RUN   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic pump_up,
  input  logic pump_dn,
  input  logic precise_sel,
  input  logic cp_hiz,
  input  logic cp_off,
  input  logic raw_mode,
  output logic lock_out
);
  localparam int unsigned CW = $clog2(BAD_LIMIT + 2);
  localparam int unsigned RW = $clog2(LONG_RUN + 1);

  logic [CW-1:0] width;
  logic          window_ok;
  logic          eval_tick;
  logic          good_cycle;
  logic          bad_cycle;
  logic          force_unlock;
  logic          locked_q;
  logic [RW-1:0] run_q;
  logic          enter_lock;
  logic          drop_lock;

  lockdet_width_meter #(.CW(CW), .SAT_VAL(BAD_LIMIT + 1)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .pump_up(pump_up), .pump_dn(pump_dn),
    .width_o(width), .window_ok_o(window_ok)
  );

  assign eval_tick    = ref_tick && window_ok;
  assign good_cycle   = width_is_good(32'(width), GOOD_LIMIT);
  assign bad_cycle    = width_is_bad(32'(width), BAD_LIMIT);
  assign force_unlock = cp_hiz || cp_off;

  lockdet_run_ctrl #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN), .RW(RW)) u_run (
    .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick),
    .good_cycle(good_cycle), .bad_cycle(bad_cycle),
    .force_unlock(force_unlock), .precise_sel(precise_sel),
    .locked_o(locked_q), .run_o(run_q),
    .enter_lock_o(enter_lock), .drop_lock_o(drop_lock)
  );

  assign lock_out = raw_mode ? ~(pump_up | pump_dn) : locked_q;
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int unsigned RW       = 3,
  parameter int unsigned LONG_RUN = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eval_tick,
  input logic          good_cycle,
  input logic          bad_cycle,
  input logic          force_unlock,
  input logic          locked,
  input logic [RW-1:0] run,
  input logic          raw_mode,
  input logic          pump_up,
  input logic          pump_dn,
  input logic          lock_out
);
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_unlock |=> (!locked && run == '0)); // R8
  AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && eval_tick && bad_cycle && !force_unlock) |=> !locked); // R6
  AST_MID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && eval_tick && !bad_cycle && !force_unlock) |=> locked); // R7
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && eval_tick && !good_cycle && !force_unlock) |=> (!locked && run == '0)); // R5
  AST_RISE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(eval_tick)); // R3
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(LONG_RUN)); // R4
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_tick && !force_unlock) |=> $stable(locked)); // R2
  AST_RAW_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_mode && (pump_up || pump_dn)) |-> !lock_out); // R9
endmodule

bind pll_lock_monitor lockdet_checker #(.RW(RW), .LONG_RUN(LONG_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick), .good_cycle(good_cycle),
  .bad_cycle(bad_cycle), .force_unlock(force_unlock), .locked(locked_q),
  .run(run_q), .raw_mode(raw_mode), .pump_up(pump_up), .pump_dn(pump_dn),
  .lock_out(lock_out)
);

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rst_n, ref_tick, pump_up, pump_dn, precise_sel, cp_hiz, cp_off, raw_mode;
  logic lock_out;
  int   total = 0;
  int   fails = 0;

  always #5 clk = ~clk;

  pll_lock_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pump_up(pump_up), .pump_dn(pump_dn),
    .precise_sel(precise_sel), .cp_hiz(cp_hiz), .cp_off(cp_off), .raw_mode(raw_mode),
    .lock_out(lock_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_tick = 1'b0; pump_up = 1'b0; pump_dn = 1'b0;
    precise_sel = 1'b0; cp_hiz = 1'b0; cp_off = 1'b0; raw_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // one window with a pulse of exactly w cycles, closed by the evaluating strobe
  task automatic feed(input int w, input bit use_dn);
    for (int i = 0; i < PER - 1; i++) begin
      pump_up = !use_dn && (i < w);
      pump_dn = use_dn && (i < w);
      @(negedge clk);
    end
    pump_up = 1'b0; pump_dn = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk(lock_out, 1'b0, "R1 unlocked after reset");
    tick();
    chk(lock_out, 1'b0, "R1 first strobe not evaluated");
  endtask

  task automatic t_short_run();
    do_reset(); tick();
    feed(5, 0);
    feed(14, 0);
    chk(lock_out, 1'b0, "R3 two goods no lock");
    feed(5, 0);
    chk(lock_out, 1'b1, "R3 R2 third good (width 14 good) locks");
  endtask

  task automatic t_long_run();
    do_reset(); precise_sel = 1'b1; tick();
    repeat (4) feed(3, 0);
    chk(lock_out, 1'b0, "R4 four goods no lock");
    feed(3, 1);
    chk(lock_out, 1'b1, "R4 fifth good locks");
  endtask

  task automatic t_clear_and_limits();
    do_reset(); tick();
    feed(5, 0); feed(5, 0); feed(15, 0);
    chk(lock_out, 1'b0, "R5 width 15 not good");
    feed(5, 0); feed(5, 0);
    chk(lock_out, 1'b0, "R5 run restarted");
    feed(5, 0);
    chk(lock_out, 1'b1, "R5 lock after fresh run");
    feed(30, 0);
    chk(lock_out, 1'b1, "R7 width 30 keeps lock");
    feed(15, 1);
    chk(lock_out, 1'b1, "R7 width 15 keeps lock");
    feed(31, 1);
    chk(lock_out, 1'b0, "R6 width 31 drops lock");
    feed(5, 0);
    chk(lock_out, 1'b0, "R6 one good after drop no lock");
  endtask

  task automatic t_force();
    do_reset(); tick();
    repeat (3) feed(2, 0);
    chk(lock_out, 1'b1, "R8 locked before force");
    cp_hiz = 1'b1;
    @(negedge clk);
    chk(lock_out, 1'b0, "R8 hiz unlocks without strobe");
    repeat (3) feed(2, 0);
    chk(lock_out, 1'b0, "R8 goods ignored while forced");
    cp_hiz = 1'b0;
    feed(2, 0); feed(2, 0);
    chk(lock_out, 1'b0, "R8 run restarted after release");
    feed(2, 0);
    chk(lock_out, 1'b1, "R8 relock after full run");
    cp_off = 1'b1;
    @(negedge clk);
    chk(lock_out, 1'b0, "R8 power-down unlocks");
    cp_off = 1'b0;
  endtask

  task automatic t_precision_change();
    do_reset(); precise_sel = 1'b1; tick();
    repeat (3) feed(4, 0);
    chk(lock_out, 1'b0, "R10 three goods under long setting");
    precise_sel = 1'b0;
    feed(4, 0);
    chk(lock_out, 1'b1, "R10 switch to short locks at next evaluation");
  endtask

  task automatic t_raw();
    do_reset(); raw_mode = 1'b1;
    #1 chk(lock_out, 1'b1, "R9 raw high without pulse");
    pump_up = 1'b1;
    #1 chk(lock_out, 1'b0, "R9 raw low on up pulse");
    pump_up = 1'b0; pump_dn = 1'b1;
    #1 chk(lock_out, 1'b0, "R9 raw low on down pulse");
    pump_dn = 1'b0;
    @(negedge clk);
    raw_mode = 1'b0;
    #1 chk(lock_out, 1'b0, "R9 counting state untouched by raw mode");
  endtask

  initial begin
    t_reset();
    t_short_run();
    t_long_run();
    t_clear_and_limits();
    t_force();
    t_precision_change();
    t_raw();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule